// File: doc/BRIEF.md
# Line Prefetch Engine

The engine sits beside a cache's tag lookup and issues line-fill requests ahead of the processor. Each lookup event carries an address and a hit flag. When an event qualifies, the engine aligns the address down to the configured line size. It then issues a burst of line-fill requests that walk away from that line by a fixed stride, either upward or downward. The trigger selection decides which events qualify: misses, hits or both. The burst length is bounded by a byte budget.

In window mode the engine reacts only to events whose address lies inside one of two programmable address windows. A burst never leaves the window that started it. A suspend pulse parks the engine and reports whether it was live beforehand. A later resume pulse takes that flag back and restores the earlier state. Requests leave on a valid/ready port. While a burst is running, further events are dropped rather than queued. A suspend that arrives mid-burst ends the burst once the pending request is accepted.

Top module: `line_prefetch_engine`

## Requirements
- R1: After reset no request is offered (`req_valid_o` = 0) and the suspend status `susp_flag_o` reads 0.
- R2: `cfg_trig_i` selects the qualifying events: 0 accepts misses only (`ev_hit_i` = 0), 1 accepts hits only, 2 accepts both, and 3 accepts none.
- R3: `cfg_line_sel_i` sets the line size: 0 = 16 bytes, 1 = 32 bytes, 2 = 64 bytes. The event address is aligned down to the line size, and every request address is line aligned.
- R4: `cfg_back_i` = 0 makes each request address greater than the previous one (or greater than the aligned event address) by the stride. `cfg_back_i` = 1 makes it smaller by the stride. The stride is (`cfg_step_i` + 1) lines.
- R5: A burst issues floor(`cfg_burst_i` / line size) requests. A budget smaller than one line issues no request.
- R6: With `cfg_win_mode_i` = 1, an event qualifies only if its address a satisfies base <= a < base + len for window 0 or window 1. Window 0 is tested first.
- R7: In window mode a burst ends before the first request address that falls outside the window that started it. If the first address is already outside, nothing is issued.
- R8: An event that arrives while a burst is in progress is dropped. It does not start a burst later.
- R9: While `req_valid_o` is high and `req_ready_i` is low, `req_valid_o` stays high and `req_addr_o` stays unchanged in the next cycle.
- R10: A `suspend_i` pulse sets `susp_flag_o` to 1 if the engine was enabled and not suspended, and to 0 otherwise. After the pulse, events start no burst.
- R11: A `resume_i` pulse with `resume_flag_i` = 1 makes events qualify again. With `resume_flag_i` = 0 the engine stays suspended.
- R12: With `cfg_en_i` = 0 events start no burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_en_i | input | 1 | Prefetch enable |
| cfg_win_mode_i | input | 1 | 1 = react only inside the two windows |
| cfg_back_i | input | 1 | 1 = walk toward lower addresses |
| cfg_step_i | input | STEP_W | Stride in lines, minus one |
| cfg_trig_i | input | 2 | Trigger selection (R2) |
| cfg_line_sel_i | input | 2 | Line size selection (R3) |
| cfg_burst_i | input | BW | Byte budget per burst |
| cfg_base0_i | input | AW | Window 0 start |
| cfg_len0_i | input | AW | Window 0 length in bytes |
| cfg_base1_i | input | AW | Window 1 start |
| cfg_len1_i | input | AW | Window 1 length in bytes |
| ev_valid_i | input | 1 | Lookup event strobe |
| ev_addr_i | input | AW | Lookup event address |
| ev_hit_i | input | 1 | 1 = lookup hit, 0 = miss |
| suspend_i | input | 1 | Suspend pulse |
| resume_i | input | 1 | Resume pulse |
| resume_flag_i | input | 1 | Status to restore on resume |
| req_valid_o | output | 1 | Line-fill request valid |
| req_ready_i | input | 1 | Line-fill request accepted |
| req_addr_o | output | AW | Line-fill request address |
| susp_flag_o | output | 1 | Engine was live before the last suspend |

## Verification
The hardest situation to reach is an event that arrives while a burst is still in flight. The bench holds `req_ready_i` low so that the first burst cannot progress, fires a second qualifying event, and then releases ready. The scoreboard must then see exactly the first burst's addresses and nothing from the second event. Window truncation is reached by placing an event near the top of window 1, so that the stride walks out of it after a few lines. A backward event at the window's base shows the case where the very first address is already outside the window.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic [1:0] {
    TRIG_MISS = 2'd0,
    TRIG_HIT  = 2'd1,
    TRIG_BOTH = 2'd2,
    TRIG_NONE = 2'd3
  } trig_e;

  localparam int unsigned MAX_LSEL = 2;
endpackage

// File: rtl/pf_window_cmp.sv
module pf_window_cmp #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] len_i,
  input  logic [AW-1:0] addr_i,
  output logic          hit_o
);
  logic [AW:0] lo, hi, a;
  always_comb begin
    lo    = {1'b0, base_i};
    hi    = {1'b0, base_i} + {1'b0, len_i};
    a     = {1'b0, addr_i};
    hit_o = (a >= lo) && (a < hi);
  end
endmodule

// File: rtl/pf_trig_qual.sv
module pf_trig_qual (
  input  logic       ev_valid_i,
  input  logic       ev_hit_i,
  input  logic [1:0] trig_i,
  input  logic       live_i,
  input  logic       busy_i,
  output logic       qual_o
);
  import pf_pkg::*;
  logic kind_ok;
  always_comb begin
    unique case (trig_e'(trig_i))
      TRIG_MISS: kind_ok = !ev_hit_i;
      TRIG_HIT:  kind_ok = ev_hit_i;
      TRIG_BOTH: kind_ok = 1'b1;
      default:   kind_ok = 1'b0;
    endcase
    qual_o = ev_valid_i && live_i && !busy_i && kind_ok;
  end
endmodule

// File: rtl/pf_susp_ctl.sv
module pf_susp_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic suspend_i,
  input  logic resume_i,
  input  logic resume_flag_i,
  output logic held_o,
  output logic flag_o,
  output logic live_o
);
  logic held_q, flag_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= 1'b0;
      flag_q <= 1'b0;
    end else if (suspend_i) begin
      flag_q <= en_i && !held_q;
      held_q <= 1'b1;
    end else if (resume_i) begin
      held_q <= !resume_flag_i;
    end
  end
  assign held_o = held_q;
  assign flag_o = flag_q;
  assign live_o = en_i && !held_q;
endmodule

// File: rtl/pf_burst_seq.sv
module pf_burst_seq #(
  parameter int unsigned AW = 32,
  parameter int unsigned BW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] first_addr_i,
  input  logic [AW-1:0] stride_i,
  input  logic          back_i,
  input  logic [BW-1:0] line_i,
  input  logic [BW-1:0] rem_init_i,
  input  logic          win_mode_i,
  input  logic          win_sel_i,
  input  logic          held_i,
  input  logic          ready_i,
  input  logic          next_in_win_i,
  output logic          busy_o,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] next_addr_o,
  output logic          win_sel_o
);
  logic          busy_q, back_q, wmode_q, wsel_q;
  logic [AW-1:0] addr_q, stride_q;
  logic [BW-1:0] rem_q, line_q;
  logic          more;

  assign next_addr_o = back_q ? (addr_q - stride_q) : (addr_q + stride_q);
  assign more = (rem_q >= line_q) && !held_i && (!wmode_q || next_in_win_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      back_q   <= 1'b0;
      wmode_q  <= 1'b0;
      wsel_q   <= 1'b0;
      addr_q   <= '0;
      stride_q <= '0;
      rem_q    <= '0;
      line_q   <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q   <= 1'b1;
        addr_q   <= first_addr_i;
        stride_q <= stride_i;
        back_q   <= back_i;
        line_q   <= line_i;
        rem_q    <= rem_init_i;
        wmode_q  <= win_mode_i;
        wsel_q   <= win_sel_i;
      end
    end else if (ready_i) begin
      if (more) begin
        addr_q <= next_addr_o;
        rem_q  <= rem_q - line_q;
      end else begin
        busy_q <= 1'b0;
      end
    end
  end

  assign busy_o    = busy_q;
  assign addr_o    = addr_q;
  assign win_sel_o = wsel_q;
endmodule

// File: rtl/line_prefetch_engine.sv
module line_prefetch_engine #(
  parameter int unsigned AW       = 32,
  parameter int unsigned BW       = 16,
  parameter int unsigned STEP_W   = 4,
  parameter int unsigned MIN_LINE = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_en_i,
  input  logic              cfg_win_mode_i,
  input  logic              cfg_back_i,
  input  logic [STEP_W-1:0] cfg_step_i,
  input  logic [1:0]        cfg_trig_i,
  input  logic [1:0]        cfg_line_sel_i,
  input  logic [BW-1:0]     cfg_burst_i,
  input  logic [AW-1:0]     cfg_base0_i,
  input  logic [AW-1:0]     cfg_len0_i,
  input  logic [AW-1:0]     cfg_base1_i,
  input  logic [AW-1:0]     cfg_len1_i,
  input  logic              ev_valid_i,
  input  logic [AW-1:0]     ev_addr_i,
  input  logic              ev_hit_i,
  input  logic              suspend_i,
  input  logic              resume_i,
  input  logic              resume_flag_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [AW-1:0]     req_addr_o,
  output logic              susp_flag_o
);
  import pf_pkg::*;
  localparam int unsigned NWIN = 2;

  logic [1:0]    lsel;
  logic [AW-1:0] line_aw, stride, base_line, first_addr, next_addr;
  logic [BW-1:0] line_bw, rem_init;
  logic          held_w, live, busy, qual, start, win_sel, seq_wsel;
  logic [AW-1:0] win_base [NWIN];
  logic [AW-1:0] win_len  [NWIN];
  logic [NWIN-1:0] ev_in, first_in, next_in;

  always_comb begin
    lsel      = (cfg_line_sel_i > 2'(MAX_LSEL)) ? 2'(MAX_LSEL) : cfg_line_sel_i;
    line_aw   = AW'(MIN_LINE) << lsel;
    line_bw   = BW'(MIN_LINE) << lsel;
    stride    = (AW'(cfg_step_i) + AW'(1)) * line_aw;
    base_line = ev_addr_i & ~(line_aw - AW'(1));
    first_addr = cfg_back_i ? (base_line - stride) : (base_line + stride);
    rem_init  = cfg_burst_i - line_bw;
  end

  assign win_base[0] = cfg_base0_i;
  assign win_len[0]  = cfg_len0_i;
  assign win_base[1] = cfg_base1_i;
  assign win_len[1]  = cfg_len1_i;

  for (genvar r = 0; r < NWIN; r++) begin : g_win
    pf_window_cmp #(.AW(AW)) u_ev (
      .base_i(win_base[r]), .len_i(win_len[r]), .addr_i(ev_addr_i), .hit_o(ev_in[r]));
    pf_window_cmp #(.AW(AW)) u_first (
      .base_i(win_base[r]), .len_i(win_len[r]), .addr_i(first_addr), .hit_o(first_in[r]));
    pf_window_cmp #(.AW(AW)) u_next (
      .base_i(win_base[r]), .len_i(win_len[r]), .addr_i(next_addr), .hit_o(next_in[r]));
  end

  // window 0 wins when both contain the event
  assign win_sel = !ev_in[0];

  pf_susp_ctl u_susp (
    .clk_i, .rst_ni, .en_i(cfg_en_i), .suspend_i, .resume_i, .resume_flag_i,
    .held_o(held_w), .flag_o(susp_flag_o), .live_o(live));

  pf_trig_qual u_qual (
    .ev_valid_i, .ev_hit_i, .trig_i(cfg_trig_i), .live_i(live), .busy_i(busy),
    .qual_o(qual));

  assign start = qual && (cfg_burst_i >= line_bw) &&
                 (!cfg_win_mode_i || ((|ev_in) && first_in[win_sel]));

  pf_burst_seq #(.AW(AW), .BW(BW)) u_seq (
    .clk_i, .rst_ni,
    .start_i(start), .first_addr_i(first_addr), .stride_i(stride),
    .back_i(cfg_back_i), .line_i(line_bw), .rem_init_i(rem_init),
    .win_mode_i(cfg_win_mode_i), .win_sel_i(win_sel), .held_i(held_w),
    .ready_i(req_ready_i), .next_in_win_i(next_in[seq_wsel]),
    .busy_o(busy), .addr_o(req_addr_o), .next_addr_o(next_addr),
    .win_sel_o(seq_wsel));

  assign req_valid_o = busy;
endmodule

// File: rtl/pf_checker.sv
module pf_checker #(
  parameter int unsigned AW       = 32,
  parameter int unsigned MIN_LINE = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_en_i,
  input logic [1:0]    cfg_line_sel_i,
  input logic          suspend_i,
  input logic          resume_i,
  input logic          resume_flag_i,
  input logic          req_valid_o,
  input logic          req_ready_i,
  input logic [AW-1:0] req_addr_o,
  input logic          susp_flag_o,
  input logic          held_i
);
  logic [AW-1:0] chk_line;
  assign chk_line = (cfg_line_sel_i >= 2'd2) ? AW'(MIN_LINE * 4) : (AW'(MIN_LINE) << cfg_line_sel_i);

  assert_req_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o));

  assert_off_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en_i && !req_valid_o |=> !req_valid_o);

  assert_flag_capture_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspend_i |=> susp_flag_o == $past(cfg_en_i && !held_i));

  assert_held_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_i && !req_valid_o |=> !req_valid_o);

  assert_resume_live_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_i && !suspend_i && resume_flag_i |=> !held_i);

  assert_line_align_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_valid_o) |-> ((req_addr_o & (chk_line - AW'(1))) == '0));
endmodule

bind line_prefetch_engine pf_checker #(.AW(AW), .MIN_LINE(MIN_LINE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_en_i(cfg_en_i), .cfg_line_sel_i(cfg_line_sel_i),
  .suspend_i(suspend_i), .resume_i(resume_i), .resume_flag_i(resume_flag_i),
  .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_addr_o(req_addr_o),
  .susp_flag_o(susp_flag_o), .held_i(held_w));

// File: tb/sim_line_prefetch_engine.sv
module sim_line_prefetch_engine;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic        en, wmode, back, ev_valid, ev_hit, susp, resm, rflag, ready;
  logic [3:0]  step;
  logic [1:0]  trig, lsel, rdy_mode;
  logic [15:0] burst;
  logic [31:0] b0, l0, b1, l1, ev_addr, req_addr;
  logic        req_valid, sflag;

  int checks = 0, errors = 0, cyc = 0;
  string cur = "R1";
  logic [31:0] exp_q[$];
  bit held_m = 0;

  line_prefetch_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_en_i(en), .cfg_win_mode_i(wmode),
    .cfg_back_i(back), .cfg_step_i(step), .cfg_trig_i(trig), .cfg_line_sel_i(lsel),
    .cfg_burst_i(burst), .cfg_base0_i(b0), .cfg_len0_i(l0), .cfg_base1_i(b1),
    .cfg_len1_i(l1), .ev_valid_i(ev_valid), .ev_addr_i(ev_addr), .ev_hit_i(ev_hit),
    .suspend_i(susp), .resume_i(resm), .resume_flag_i(rflag),
    .req_valid_o(req_valid), .req_ready_i(ready), .req_addr_o(req_addr),
    .susp_flag_o(sflag));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    case (rdy_mode)
      2'd0: ready = 1'b1;
      2'd1: ready = cyc[0] ^ cyc[2];
      default: ready = 1'b0;
    endcase
  end

  // monitor / scoreboard
  bit prev_stall = 0;
  logic [31:0] prev_addr;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        checks++;
        if (!req_valid || req_addr != prev_addr) begin
          errors++;
          $display("FAIL R9 hold: valid=%0b addr=%h expected valid=1 addr=%h", req_valid, req_addr, prev_addr);
        end
      end
      prev_stall = req_valid && !ready;
      prev_addr  = req_addr;
      if (req_valid && ready) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL %s unexpected request: actual %h expected none", cur, req_addr);
        end else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          if (e != req_addr) begin
            errors++;
            $display("FAIL %s request address: actual %h expected %h", cur, req_addr, e);
          end
        end
      end
    end
  end

  function automatic bit in_win(logic [31:0] a, int w);
    logic [32:0] lo, hi;
    lo = (w == 0) ? {1'b0, b0} : {1'b0, b1};
    hi = lo + ((w == 0) ? {1'b0, l0} : {1'b0, l1});
    return ({1'b0, a} >= lo) && ({1'b0, a} < hi);
  endfunction

  // expected burst from the requirements
  task automatic model(input logic [31:0] a, input bit hit);
    int line, n, w;
    logic [31:0] stride, p;
    bit ok;
    ok = en && !held_m && ((trig == 0 && !hit) || (trig == 1 && hit) || trig == 2);
    if (!ok) return;
    line = 16 << ((lsel > 2) ? 2 : lsel);
    n = burst / line;
    stride = (32'(step) + 1) * line;
    w = 0;
    if (wmode) begin
      if (in_win(a, 0)) w = 0;
      else if (in_win(a, 1)) w = 1;
      else return;
    end
    p = a & ~(32'(line) - 1);
    for (int i = 0; i < n; i++) begin
      p = back ? p - stride : p + stride;
      if (wmode && !in_win(p, w)) break;
      exp_q.push_back(p);
    end
  endtask

  task automatic fire(input logic [31:0] a, input bit hit, input bit use_model);
    if (use_model) model(a, hit);
    @(posedge clk); #1;
    ev_valid = 1; ev_addr = a; ev_hit = hit;
    @(posedge clk); #1;
    ev_valid = 0;
  endtask

  task automatic drain(input string tag);
    cur = tag;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (exp_q.size() == 0 && !req_valid) break;
    end
    repeat (6) @(negedge clk);
    checks++;
    if (exp_q.size() != 0 || req_valid) begin
      errors++;
      $display("FAIL %s drain: pending %0d valid %0b expected 0 0", tag, exp_q.size(), req_valid);
      exp_q.delete();
    end
  endtask

  task automatic pulse_susp();
    @(posedge clk); #1; susp = 1;
    @(posedge clk); #1; susp = 0;
    held_m = 1;
  endtask

  task automatic pulse_resume(input bit f);
    @(posedge clk); #1; resm = 1; rflag = f;
    @(posedge clk); #1; resm = 0;
    held_m = !f;
  endtask

  task automatic chk_flag(input bit e, input string tag);
    @(negedge clk);
    checks++;
    if (sflag !== e) begin
      errors++;
      $display("FAIL %s suspend flag: actual %0b expected %0b", tag, sflag, e);
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    en = 1; wmode = 0; back = 0; step = 0; trig = 0; lsel = 1; burst = 128;
    b0 = 32'h1000; l0 = 32'h100; b1 = 32'h8000; l1 = 32'h80;
    ev_valid = 0; ev_addr = 0; ev_hit = 0; susp = 0; resm = 0; rflag = 0; rdy_mode = 0;
    ready = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    checks++;
    if (req_valid !== 0 || sflag !== 0) begin
      errors++;
      $display("FAIL R1 reset: valid=%0b flag=%0b expected 0 0", req_valid, sflag);
    end

    // R3 R4 R5: forward, 32-byte lines, 4 requests
    cur = "R4"; fire(32'h0002_0010, 0, 1); drain("R4");
    // R2: hit ignored under miss-only
    cur = "R2"; fire(32'h0002_0400, 1, 1); drain("R2");
    // R4: backward, stride of 3 lines, 16-byte lines, stalling ready
    back = 1; step = 2; lsel = 0; burst = 48; rdy_mode = 1;
    cur = "R4"; fire(32'h0003_0105, 0, 1); drain("R4");
    back = 0; step = 0; rdy_mode = 0;
    // R2 both / hit only / none
    trig = 2; cur = "R2"; fire(32'h0004_0000, 1, 1); drain("R2");
    trig = 1; fire(32'h0004_1000, 0, 1); drain("R2");
    fire(32'h0004_2000, 1, 1); drain("R2");
    trig = 3; fire(32'h0004_3000, 1, 1); fire(32'h0004_3000, 0, 1); drain("R2");
    trig = 0;
    // R5: budget below one line
    burst = 10; cur = "R5"; fire(32'h0005_0000, 0, 1); drain("R5");
    // R3: 64-byte lines, unaligned address, step field 1
    burst = 200; lsel = 2; step = 1; cur = "R3"; fire(32'h0001_2377, 0, 1); drain("R3");
    step = 0; lsel = 0; burst = 256;
    // R6 R7: window mode
    wmode = 1;
    cur = "R6"; fire(32'h0000_5000, 0, 1); drain("R6");
    cur = "R7"; fire(32'h0000_8040, 0, 1); drain("R7");
    back = 1; fire(32'h0000_1000, 0, 1); drain("R7");
    fire(32'h0000_1080, 0, 1); drain("R6");
    back = 0; wmode = 0; burst = 64;
    // R8: second event during a stalled burst is dropped
    rdy_mode = 2; cur = "R8";
    fire(32'h0006_0000, 0, 1);
    fire(32'h0007_0000, 0, 0);
    repeat (3) @(posedge clk);
    rdy_mode = 0; drain("R8");
    // R10 R11
    pulse_susp(); chk_flag(1, "R10");
    cur = "R10"; fire(32'h0008_0000, 0, 1); drain("R10");
    pulse_resume(1); cur = "R11"; fire(32'h0008_1000, 0, 1); drain("R11");
    pulse_susp(); chk_flag(1, "R10");
    pulse_resume(0); fire(32'h0008_2000, 0, 1); drain("R11");
    pulse_susp(); chk_flag(0, "R10");
    pulse_resume(1); fire(32'h0008_3000, 0, 1); drain("R11");
    // R12: disabled
    en = 0; cur = "R12"; fire(32'h0009_0000, 0, 1); drain("R12");
    pulse_susp(); chk_flag(0, "R10");
    pulse_resume(1); en = 1;
    fire(32'h0009_1000, 0, 1); drain("R12");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule